// File: doc/BRIEF.md
# Bivium-style NLFSR keystream generator

This block is a 177-stage nonlinear feedback shift register in the style of a two-register trivium-family cipher. It serves as a pseudo-random bit source. Every rising clock edge moves each stage one position to the right, toward higher indices. Two stages do not simply copy their neighbour. The head stage (index 0) is fed by a nonlinear function of stages near the tail. The middle stage (index 93) is fed by a nonlinear function of the first segment. One keystream bit per cycle is the XOR of four taps.

A load-select input switches both injection points into load mode. In load mode the head takes a manually supplied bit and the middle stage takes stage 91 directly, so the register behaves like a plain shift line. Holding load mode with a zero manual bit for 177 cycles clears the register. Shifting in chosen bits instead seeds it. In run mode a lock-up guard writes a 1 into the head whenever all 177 stages are zero, so the register cannot stall in the all-zero state.

Eight observation bits expose the head input, several taps and the keystream bit. These let an outside observer check that the register is consistent with itself.

Top module: `nlfsr_keygen`

## Requirements
- R1: On each rising edge with rstN high, every stage n other than 0 and 93 takes the previous value of stage n-1.
- R2: In run mode (loadSel=0), stage 93 takes (s90 AND s91) XOR s65 XOR s92 XOR s170 at the edge.
- R3: In run mode with at least one stage set, stage 0 takes (s174 AND s175) XOR s161 XOR s176 XOR s68 at the edge.
- R4: obsBus[7] is the keystream bit s65 XOR s92 XOR s161 XOR s176 of the current state.
- R5: In run mode with all 177 stages zero, stage 0 takes 1 at the edge, and obsBus[0] reads 1 in that cycle.
- R6: In load mode (loadSel=1), stage 0 takes manualBit and stage 93 takes s91 at the edge. The zero guard has no effect in load mode.
- R7: obsBus bit positions: [0] is the value stage 0 will take at the next edge, [1]=s68, [2]=(s174 AND s175) XOR s161 XOR s176, [3]=s65, [4]=s92, [5]=s161, [6]=s176.
- R8: In run mode with a nonzero state, obsBus[0] = obsBus[1] XOR obsBus[2], and obsBus[7] = XOR of obsBus[6:3] at all times.
- R9: rstN low at a rising edge clears all stages to zero (synchronous, active low).
- R10: Holding loadSel=1 with manualBit=0 for 177 edges clears the register, after which obsBus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadSel | input | 1 | 1 = load mode (manual bit at head, bypass at stage 93), 0 = run mode |
| manualBit | input | 1 | Bit shifted into stage 0 in load mode |
| obsBus | output | 8 | Observation taps and keystream bit, mapping in R7 |

## Verification
The hardest situation to reach is the middle-stage bypass in load mode. Stage 93 is not a port, and its content only appears on the stage-161 tap 68 cycles later. The bench seeds the register with a long pseudo-random pattern in load mode, then keeps comparing every observation bit each cycle against an independent model through a long run phase. Any wrong value entered at stage 93 during loading therefore shows up on obsBus[5] and the keystream. The zero guard is reached both straight after reset and after a full 177-cycle zeroize.

// File: rtl/nlfsr_pkg.sv
package nlfsr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeManual;  // head stage loads the manual bit
    logic injectOne;   // head stage forced to 1 (lock-up guard)
    logic bypassMid;   // middle stage copies its bypass source
  } ctrl_t;

  localparam int OBS_W = 8;

endpackage

// File: rtl/nlfsr_ctrl.sv
module nlfsr_ctrl
  import nlfsr_pkg::*;
(
  input  logic  loadSel,
  input  logic  allZero,
  output ctrl_t strobe
);

  always_comb begin
    strobe            = '0;
    strobe.takeManual = loadSel;
    strobe.bypassMid  = loadSel;
    // guard only in run mode so a zeroize can complete
    strobe.injectOne  = !loadSel && allZero;
  end

endmodule

// File: rtl/nlfsr_datapath.sv
module nlfsr_datapath
  import nlfsr_pkg::*;
#(
  parameter int STAGES     = 177,
  parameter int MID_DST    = 93,
  parameter int MID_AND_A  = 90,
  parameter int MID_AND_B  = 91,
  parameter int MID_LIN    = 65,
  parameter int MID_FAR    = 170,
  parameter int MID_BYPASS = 91,
  parameter int HEAD_AND_A = 174,
  parameter int HEAD_AND_B = 175,
  parameter int HEAD_LIN   = 161,
  parameter int HEAD_FAR   = 68
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strobe,
  input  logic              manualBit,
  output logic              allZero,
  output logic [STAGES-1:0] stateQ,
  output logic [OBS_W-1:0]  obsBus
);

  localparam int LAST     = STAGES - 1;
  localparam int MID_PREV = MID_DST - 1;

  logic [STAGES-1:0] stateD;
  logic headTerm;
  logic headFb;
  logic midFb;
  logic headIn;
  logic midIn;
  logic keyBit;

  assign allZero = ~|stateQ;

  always_comb begin
    headTerm = (stateQ[HEAD_AND_A] & stateQ[HEAD_AND_B]) ^ stateQ[HEAD_LIN] ^ stateQ[LAST];
    headFb   = headTerm ^ stateQ[HEAD_FAR];
    midFb    = (stateQ[MID_AND_A] & stateQ[MID_AND_B]) ^ stateQ[MID_LIN]
               ^ stateQ[MID_PREV] ^ stateQ[MID_FAR];
    keyBit   = stateQ[MID_LIN] ^ stateQ[MID_PREV] ^ stateQ[HEAD_LIN] ^ stateQ[LAST];
  end

  always_comb begin
    if (strobe.takeManual)     headIn = manualBit;
    else if (strobe.injectOne) headIn = 1'b1;
    else                       headIn = headFb;
    midIn = strobe.bypassMid ? stateQ[MID_BYPASS] : midFb;
  end

  // shift line with two injection points
  always_comb begin
    stateD          = {stateQ[LAST-1:0], headIn};
    stateD[MID_DST] = midIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateD;
  end

  always_comb begin
    obsBus    = '0;
    obsBus[0] = headIn;
    obsBus[1] = stateQ[HEAD_FAR];
    obsBus[2] = headTerm;
    obsBus[3] = stateQ[MID_LIN];
    obsBus[4] = stateQ[MID_PREV];
    obsBus[5] = stateQ[HEAD_LIN];
    obsBus[6] = stateQ[LAST];
    obsBus[7] = keyBit;
  end

endmodule

// File: rtl/nlfsr_keygen.sv
module nlfsr_keygen
  import nlfsr_pkg::*;
#(
  parameter int STAGES     = 177,
  parameter int MID_DST    = 93,
  parameter int MID_AND_A  = 90,
  parameter int MID_AND_B  = 91,
  parameter int MID_LIN    = 65,
  parameter int MID_FAR    = 170,
  parameter int MID_BYPASS = 91,
  parameter int HEAD_AND_A = 174,
  parameter int HEAD_AND_B = 175,
  parameter int HEAD_LIN   = 161,
  parameter int HEAD_FAR   = 68
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadSel,
  input  logic             manualBit,
  output logic [OBS_W-1:0] obsBus
);

  ctrl_t             strobe;
  logic              allZero;
  logic [STAGES-1:0] regState;

  nlfsr_ctrl u_ctrl (
    .loadSel (loadSel),
    .allZero (allZero),
    .strobe  (strobe)
  );

  nlfsr_datapath #(
    .STAGES(STAGES), .MID_DST(MID_DST), .MID_AND_A(MID_AND_A),
    .MID_AND_B(MID_AND_B), .MID_LIN(MID_LIN), .MID_FAR(MID_FAR),
    .MID_BYPASS(MID_BYPASS), .HEAD_AND_A(HEAD_AND_A), .HEAD_AND_B(HEAD_AND_B),
    .HEAD_LIN(HEAD_LIN), .HEAD_FAR(HEAD_FAR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .manualBit (manualBit),
    .allZero   (allZero),
    .stateQ    (regState),
    .obsBus    (obsBus)
  );

endmodule

// File: rtl/nlfsr_keygen_chk.sv
module nlfsr_keygen_chk #(
  parameter int STAGES = 177
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadSel,
  input logic              manualBit,
  input logic [7:0]        obsBus,
  input logic [STAGES-1:0] regState,
  input logic              allZero
);

  localparam int LAST = STAGES - 1;

  // R1: plain shift outside the two injection points
  p_shift_r1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (regState[92:1] == $past(regState[91:0]))
          && (regState[LAST:94] == $past(regState[LAST-1:93])));

  // R2: middle injection in run mode
  p_mid_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadSel |=> regState[93] == $past((regState[90] & regState[91]) ^ regState[65]
                                       ^ regState[92] ^ regState[170]));

  // R3: head injection in run mode, nonzero state
  p_head_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!loadSel && !allZero) |=> regState[0] == $past((regState[174] & regState[175])
                                 ^ regState[161] ^ regState[176] ^ regState[68]));

  // R4: keystream bit
  p_keybit_r4: assert property (@(posedge clk) disable iff (!rstN)
    obsBus[7] == (regState[65] ^ regState[92] ^ regState[161] ^ regState[176]));

  // R5: lock-up guard
  p_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadSel && allZero) |=> regState[0] && $countones(regState) == 1);

  // R6: load mode
  p_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadSel |=> (regState[0] == $past(manualBit)) && (regState[93] == $past(regState[91])));

  // R8: self-consistency of the observation bits
  p_selfcheck_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!loadSel && !allZero) |-> obsBus[0] == (obsBus[1] ^ obsBus[2]));

  // R9: synchronous reset clears the register
  p_reset_r9: assert property (@(posedge clk)
    !rstN |=> regState == '0);

endmodule

bind nlfsr_keygen nlfsr_keygen_chk #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadSel   (loadSel),
  .manualBit (manualBit),
  .obsBus    (obsBus),
  .regState  (regState),
  .allZero   (allZero)
);

// File: tb/nlfsr_keygen_bench.sv
module nlfsr_keygen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 177;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadSel = 1'b0;
  logic manualBit = 1'b0;
  logic [7:0] obsBus;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mdl = '0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #(CLK_PERIOD/2) clk = ~clk;

  nlfsr_keygen u_nlfsr_keygen (
    .clk(clk), .rstN(rstN), .loadSel(loadSel),
    .manualBit(manualBit), .obsBus(obsBus)
  );

  function automatic logic [7:0] expObs(logic [N-1:0] s, logic ld, logic mb);
    logic [7:0] e;
    e[1] = s[68];
    e[2] = (s[174] & s[175]) ^ s[161] ^ s[176];
    e[3] = s[65];
    e[4] = s[92];
    e[5] = s[161];
    e[6] = s[176];
    e[7] = s[65] ^ s[92] ^ s[161] ^ s[176];
    if (ld)         e[0] = mb;
    else if (s == 0) e[0] = 1'b1;
    else            e[0] = e[2] ^ s[68];
    return e;
  endfunction

  function automatic logic [N-1:0] mdlNext(logic [N-1:0] s, logic ld, logic mb);
    logic [N-1:0] n;
    logic [7:0] e;
    e = expObs(s, ld, mb);
    n = {s[N-2:0], e[0]};
    n[93] = ld ? s[91] : ((s[90] & s[91]) ^ s[65] ^ s[92] ^ s[170]);
    return n;
  endfunction

  task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: obsBus=%b expected=%b", tag, act, exp);
    end
  endtask

  // one edge with given inputs; compare at the following falling edge
  task automatic step(logic ld, logic mb, string tag);
    loadSel = ld;
    manualBit = mb;
    @(posedge clk);
    mdl = mdlNext(mdl, ld, mb);
    @(negedge clk);
    check(obsBus, expObs(mdl, ld, mb), tag);
  endtask

  function automatic logic nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  // R9: reset state, run mode shows guard at head input
  task automatic t_reset();
    rstN = 1'b0; loadSel = 1'b0; manualBit = 1'b0;
    repeat (2) @(posedge clk);
    mdl = '0;
    @(negedge clk);
    check(obsBus, 8'h01, "R9 reset state");
    rstN = 1'b1;
  endtask

  // R5: guard seeds the zero register, then the run continues (R2 R3 R4 R7 R8)
  task automatic t_guardRun(int cycles);
    int ones = 0;
    step(1'b0, 1'b0, "R5 guard seed");
    check(obsBus[0], 1'b0, "R5 head input after seed");
    for (int i = 0; i < cycles; i++) begin
      step(1'b0, 1'b0, "R3 run from seed");
      if (obsBus[7]) ones++;
      check(obsBus[0] ^ obsBus[1] ^ obsBus[2], 1'b0, "R8 head relation");
      check(obsBus[7] ^ obsBus[6] ^ obsBus[5] ^ obsBus[4] ^ obsBus[3], 1'b0, "R8 key relation");
    end
    checks++;
    if (ones == 0) begin
      errors++;
      $display("FAIL R4: keystream ones=%0d expected nonzero", ones);
    end
  endtask

  // R10: zeroize in load mode; R6: guard inert while loading zeros
  task automatic t_zeroize();
    for (int i = 0; i < N; i++) step(1'b1, 1'b0, "R6 load zeros");
    check(obsBus, 8'h00, "R10 zeroized");
    step(1'b1, 1'b0, "R6 guard off in load");
    check(obsBus, 8'h00, "R6 still zero");
    step(1'b0, 1'b0, "R5 guard after zeroize");
  endtask

  // R6 R1 R2: seed with a pattern, then long run exposes the stage-93 bypass
  task automatic t_seedRun();
    for (int i = 0; i < N; i++) step(1'b1, nextRand(), "R6 load pattern");
    for (int i = 0; i < 400; i++) step(1'b0, nextRand(), "R2 run after seed");
  endtask

  // R6: mixed load and run
  task automatic t_mixed();
    for (int i = 0; i < 300; i++) step(nextRand(), nextRand(), "R1 mixed modes");
  endtask

  // R9: reset in the middle of a run
  task automatic t_midReset();
    rstN = 1'b0;
    loadSel = 1'b0;
    @(posedge clk);
    mdl = '0;
    @(negedge clk);
    check(obsBus, 8'h01, "R9 mid-run reset");
    rstN = 1'b1;
    step(1'b0, 1'b0, "R5 guard after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_guardRun(250);
    t_zeroize();
    t_seedRun();
    t_mixed();
    t_midReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule